// File: doc/BRIEF.md
# Power-Fail Save and Restore Sequencer

This block supervises a memory made of a volatile working array backed by a nonvolatile shadow copy. It watches a digital supply-low indication, the chip-enable and write-enable strobes, and two software request pulses. From these it decides when a separate transfer engine should copy the working array into the shadow (a save) or copy the shadow back (a restore). It also gates external access while such a cycle runs.

When the supply drops, a save is started only if the working array was written since the last save or restore. Before the save starts, an access already in flight gets a short completion window. When the supply returns, a restore runs and keeps the memory unavailable for a fixed window. Software may also ask for a save or a restore. A supply drop cancels a software save but lets any restore run to its end. Every duration is a clock-cycle count parameter, so a test setup can shrink the times.

Top module: `pf_store_seq`

## Requirements
- R1: While reset is held, `busy` is 1, `access_en` is 0 and every pulse output is 0. The block leaves reset as if power had just come up, so a restore starts on the first clock edge that sees `supply_low` at 0.
- R2: If `supply_low` is seen at 1 while idle and a write happened since the last completed save or restore, the block enters a completion window of HOLD_CYC cycles. In that window `busy` is 1 and `access_en` stays 1. `save_start` then pulses on the edge that ends the window, and `access_en` drops on that same edge.
- R3: If `supply_low` is seen at 1 while idle and no write happened since the last completed save or restore, no save starts. `busy` goes to 1 and `access_en` goes to 0 on that same edge.
- R4: A power-fail save lasts SAVE_CYC cycles from the `save_start` edge. `cycle_done` pulses for one cycle on the edge that ends it. The block then stays busy with access closed until the supply returns.
- R5: While the supply is low, the first edge that sees `supply_low` at 0 pulses `restore_start`. `busy` stays 1 for RESTORE_CYC cycles from that edge. The edge that ends the window clears `busy`, opens `access_en` and pulses `cycle_done`.
- R6: A `sw_save_req` pulse seen while idle with the supply good starts a save on that edge (`save_start` pulses). The save lasts SAVE_CYC cycles and ends with a `cycle_done` pulse, after which the block is idle again.
- R7: If `supply_low` rises during a software save, the save is cancelled on that edge. `save_abort` pulses, `cycle_done` does not pulse for it, and the block waits for the supply to return with access closed.
- R8: A `sw_restore_req` pulse seen while idle with the supply good starts a restore (`restore_start` pulses) lasting SWREST_CYC cycles. A supply drop during it does not cancel it.
- R9: Software requests are ignored while the block is busy and while the supply is low; `save_start` does not pulse for them.
- R10: A write is a cycle with `ce_n` and `we_n` both 0 while `access_en` is 1. Every completed save or restore forgets earlier writes, so a later supply drop with no new write starts no save.
- R11: `save_start`, `restore_start` and `save_abort` are never high together. When both software requests arrive together, the save wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_low | input | 1 | Supply below switch threshold (already synchronised) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| sw_save_req | input | 1 | Software save request pulse |
| sw_restore_req | input | 1 | Software restore request pulse |
| busy | output | 1 | A save, restore, completion window or power-off wait is active |
| access_en | output | 1 | External reads and writes may proceed; bus may be driven |
| save_start | output | 1 | One-cycle start pulse for a save to the transfer engine |
| restore_start | output | 1 | One-cycle start pulse for a restore to the transfer engine |
| save_abort | output | 1 | One-cycle pulse: software save cancelled by supply drop |
| cycle_done | output | 1 | One-cycle pulse when a save or restore completes |

## Verification
Every result is registered, so a stimulus applied before edge e shows up right after edge e. A window of N cycles that starts at edge e ends at edge e+N. The bench drives inputs and samples outputs at falling clock edges. It counts rising edges from each stimulus, checking one cycle before each window ends and again on its last edge. This pins the HOLD_CYC, SAVE_CYC, RESTORE_CYC and SWREST_CYC lengths exactly, rather than only checking that an output eventually changes.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_PSAVE = 3'd2,
    ST_OFF   = 3'd3,
    ST_REST  = 3'd4,
    ST_SSAVE = 3'd5,
    ST_SREST = 3'd6
  } pfs_state_e;
endpackage

// File: rtl/pfs_timer.sv
module pfs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CW'(1));
endmodule

// File: rtl/pfs_wflag.sv
module pfs_wflag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  logic clr,
  output logic written
);
  logic flag_q;
  logic flag_en;
  logic flag_d;

  always_comb begin
    flag_en = wr_ok | clr;
    flag_d  = ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign written = flag_q;
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
#(
  parameter int CW         = 20,
  parameter int HOLD_CYC   = 100,
  parameter int SAVE_CYC   = 1000000,
  parameter int RESTORE_CYC = 65000,
  parameter int SWREST_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_low,
  input  logic          written,
  input  logic          sw_save,
  input  logic          sw_rest,
  input  logic          tmr_exp,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          clr_written,
  output logic          busy,
  output logic          access_en,
  output logic          save_go,
  output logic          restore_go,
  output logic          abort_p,
  output logic          done_p
);
  pfs_state_e state_q, state_d;
  logic sg_d, rg_d, ab_d, dn_d;
  logic sg_q, rg_q, ab_q, dn_q;

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    sg_d        = 1'b0;
    rg_d        = 1'b0;
    ab_d        = 1'b0;
    dn_d        = 1'b0;
    clr_written = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (supply_low) begin
          if (written) begin
            state_d  = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = CW'(HOLD_CYC);
          end else begin
            state_d = ST_OFF;
          end
        end else if (sw_save) begin
          state_d  = ST_SSAVE;
          tmr_load = 1'b1;
          tmr_val  = CW'(SAVE_CYC);
          sg_d     = 1'b1;
        end else if (sw_rest) begin
          state_d  = ST_SREST;
          tmr_load = 1'b1;
          tmr_val  = CW'(SWREST_CYC);
          rg_d     = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          state_d  = ST_PSAVE;
          tmr_load = 1'b1;
          tmr_val  = CW'(SAVE_CYC);
          sg_d     = 1'b1;
        end
      end
      ST_PSAVE: begin
        if (tmr_exp) begin
          state_d     = ST_OFF;
          dn_d        = 1'b1;
          clr_written = 1'b1;
        end
      end
      ST_OFF: begin
        if (!supply_low) begin
          state_d  = ST_REST;
          tmr_load = 1'b1;
          tmr_val  = CW'(RESTORE_CYC);
          rg_d     = 1'b1;
        end
      end
      ST_REST, ST_SREST: begin
        if (tmr_exp) begin
          state_d     = ST_IDLE;
          dn_d        = 1'b1;
          clr_written = 1'b1;
        end
      end
      ST_SSAVE: begin
        if (supply_low) begin
          state_d = ST_OFF;
          ab_d    = 1'b1;
        end else if (tmr_exp) begin
          state_d     = ST_IDLE;
          dn_d        = 1'b1;
          clr_written = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      sg_q    <= 1'b0;
      rg_q    <= 1'b0;
      ab_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sg_q    <= sg_d;
      rg_q    <= rg_d;
      ab_q    <= ab_d;
      dn_q    <= dn_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign access_en  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign save_go    = sg_q;
  assign restore_go = rg_q;
  assign abort_p    = ab_q;
  assign done_p     = dn_q;

  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sg_q, rg_q, ab_q}));

  a_r3_clean_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && supply_low && !written) |=> (state_q == ST_OFF && !sg_q));

  a_r5_rise_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !supply_low) |=> rg_q);

  a_r7_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    ab_q |-> (!dn_q && state_q == ST_OFF));

  a_r8_restore_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SREST && supply_low && !tmr_exp) |=> (state_q == ST_SREST));
endmodule

// File: rtl/pf_store_seq.sv
module pf_store_seq #(
  parameter int HOLD_CYC    = 100,
  parameter int SAVE_CYC    = 1000000,
  parameter int RESTORE_CYC = 65000,
  parameter int SWREST_CYC  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic ce_n,
  input  logic we_n,
  input  logic sw_save_req,
  input  logic sw_restore_req,
  output logic busy,
  output logic access_en,
  output logic save_start,
  output logic restore_start,
  output logic save_abort,
  output logic cycle_done
);
  localparam int MAX_A = (SAVE_CYC > RESTORE_CYC) ? SAVE_CYC : RESTORE_CYC;
  localparam int MAX_B = (HOLD_CYC > SWREST_CYC) ? HOLD_CYC : SWREST_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_C + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_exp;
  logic          written;
  logic          clr_written;
  logic          wr_ok;

  assign wr_ok = ~ce_n & ~we_n & access_en;

  pfs_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  pfs_wflag u_wflag (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok),
    .clr     (clr_written),
    .written (written)
  );

  pfs_fsm #(
    .CW          (CW),
    .HOLD_CYC    (HOLD_CYC),
    .SAVE_CYC    (SAVE_CYC),
    .RESTORE_CYC (RESTORE_CYC),
    .SWREST_CYC  (SWREST_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_low  (supply_low),
    .written     (written),
    .sw_save     (sw_save_req),
    .sw_rest     (sw_restore_req),
    .tmr_exp     (tmr_exp),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .clr_written (clr_written),
    .busy        (busy),
    .access_en   (access_en),
    .save_go     (save_start),
    .restore_go  (restore_start),
    .abort_p     (save_abort),
    .done_p      (cycle_done)
  );

  a_r10_clean_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> !written);

  a_r2_gate_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (save_start || restore_start) |-> !access_en);
endmodule

// File: tb/tb_pf_store_seq.sv
module tb_pf_store_seq;
  localparam int D = 4;
  localparam int S = 20;
  localparam int R = 12;
  localparam int W = 6;

  logic clk, rst_n, supply_low, ce_n, we_n, sw_save_req, sw_restore_req;
  logic busy, access_en, save_start, restore_start, save_abort, cycle_done;
  int checks, failures, cyc;
  bit finished;

  pf_store_seq #(.HOLD_CYC(D), .SAVE_CYC(S), .RESTORE_CYC(R), .SWREST_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .ce_n(ce_n), .we_n(we_n),
    .sw_save_req(sw_save_req), .sw_restore_req(sw_restore_req),
    .busy(busy), .access_en(access_en), .save_start(save_start),
    .restore_start(restore_start), .save_abort(save_abort), .cycle_done(cycle_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write();
    ce_n = 1'b0; we_n = 1'b0;
    step(1);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic power_up(string req);
    supply_low = 1'b0;
    step(1);
    check(req, "restore_start on rise", restore_start, 1'b1);
    check(req, "access closed in restore", access_en, 1'b0);
    step(R - 1);
    check(req, "busy before window end", busy, 1'b1);
    step(1);
    check(req, "busy clear at window end", busy, 1'b0);
    check(req, "done at window end", cycle_done, 1'b1);
    check(req, "access open after restore", access_en, 1'b1);
  endtask

  // R1 / R5: reset state and power-up restore
  task automatic t_reset();
    rst_n = 1'b0; supply_low = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    sw_save_req = 1'b0; sw_restore_req = 1'b0;
    step(3);
    check("R1", "busy in reset", busy, 1'b1);
    check("R1", "access_en in reset", access_en, 1'b0);
    check("R1", "save_start in reset", save_start, 1'b0);
    check("R1", "restore_start in reset", restore_start, 1'b0);
    check("R1", "done in reset", cycle_done, 1'b0);
    rst_n = 1'b1;
    power_up("R5");
    step(1);
    check("R5", "done is one cycle", cycle_done, 1'b0);
  endtask

  // R2 / R4: power fail after a write
  task automatic t_dirty_fail();
    do_write();
    supply_low = 1'b1;
    step(1);
    check("R2", "busy in hold", busy, 1'b1);
    check("R2", "access open in hold", access_en, 1'b1);
    check("R2", "no save yet", save_start, 1'b0);
    step(D - 1);
    check("R2", "still holding", save_start, 1'b0);
    check("R2", "access open end of hold", access_en, 1'b1);
    step(1);
    check("R2", "save_start after hold", save_start, 1'b1);
    check("R2", "access closed in save", access_en, 1'b0);
    step(S - 1);
    check("R4", "no done before save end", cycle_done, 1'b0);
    step(1);
    check("R4", "done at save end", cycle_done, 1'b1);
    check("R4", "busy after save", busy, 1'b1);
    step(3);
    check("R4", "stays off while low", busy, 1'b1);
    check("R4", "no restore while low", restore_start, 1'b0);
    power_up("R5");
  endtask

  // R3 / R9 / R10: power fail with no write since last restore
  task automatic t_clean_fail();
    supply_low = 1'b1;
    step(1);
    check("R3", "no save on clean fail", save_start, 1'b0);
    check("R3", "access closed at once", access_en, 1'b0);
    check("R10", "restore forgot writes", busy, 1'b1);
    sw_save_req = 1'b1;
    step(1);
    sw_save_req = 1'b0;
    check("R9", "sw save inhibited while low", save_start, 1'b0);
    step(4);
    check("R3", "still no save", save_start, 1'b0);
    power_up("R5");
  endtask

  // R6 / R11 / R10: software save, wins over restore
  task automatic t_sw_save();
    do_write();
    sw_save_req = 1'b1; sw_restore_req = 1'b1;
    step(1);
    sw_save_req = 1'b0; sw_restore_req = 1'b0;
    check("R6", "save_start on request", save_start, 1'b1);
    check("R11", "save wins, no restore", restore_start, 1'b0);
    check("R6", "access closed", access_en, 1'b0);
    step(S - 1);
    check("R6", "busy before end", busy, 1'b1);
    step(1);
    check("R6", "done at end", cycle_done, 1'b1);
    check("R6", "idle after sw save", busy, 1'b0);
    supply_low = 1'b1;
    step(1);
    check("R10", "sw save forgot write: no hold", access_en, 1'b0);
    check("R10", "no save after sw save", save_start, 1'b0);
    power_up("R5");
  endtask

  // R7: software save cancelled by supply drop
  task automatic t_sw_abort();
    bit saw_done;
    do_write();
    sw_save_req = 1'b1;
    step(1);
    sw_save_req = 1'b0;
    check("R7", "save started", save_start, 1'b1);
    step(4);
    supply_low = 1'b1;
    step(1);
    check("R7", "abort pulse", save_abort, 1'b1);
    check("R7", "no done on abort", cycle_done, 1'b0);
    check("R7", "access closed after abort", access_en, 1'b0);
    saw_done = 1'b0;
    for (int i = 0; i < S; i++) begin
      step(1);
      if (cycle_done) saw_done = 1'b1;
    end
    check("R7", "no later done", saw_done, 1'b0);
    check("R7", "still waiting for supply", busy, 1'b1);
    power_up("R5");
  endtask

  // R8 / R9: software restore survives supply drop
  task automatic t_sw_restore();
    sw_restore_req = 1'b1;
    step(1);
    sw_restore_req = 1'b0;
    check("R8", "restore_start on request", restore_start, 1'b1);
    supply_low = 1'b1; sw_save_req = 1'b1;
    step(1);
    sw_save_req = 1'b0;
    check("R8", "not aborted by drop", busy, 1'b1);
    check("R8", "no abort pulse", save_abort, 1'b0);
    check("R9", "sw save ignored while busy", save_start, 1'b0);
    step(W - 2);
    check("R8", "busy before end", busy, 1'b1);
    step(1);
    check("R8", "done at end", cycle_done, 1'b1);
    check("R8", "idle for one cycle", busy, 1'b0);
    step(1);
    check("R3", "off without save", save_start, 1'b0);
    check("R3", "access closed", access_en, 1'b0);
    power_up("R5");
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        finished = 1'b1;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    t_reset();
    t_dirty_fail();
    t_clean_fail();
    t_sw_save();
    t_sw_abort();
    t_sw_restore();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule